// File: doc/BRIEF.md
# Banked Pipelined Min-Heap Priority Queue

This block is a binary min-heap priority queue. Each entry pairs a key with a payload index. It is meant to keep buffered entries ordered by a score, for example how far down a tree path each entry can be placed, and to take one operation per accepted request. Two operations are supported. Insert places a new entry and sifts it upward. Extract removes the entry with the smallest key and sifts the former last entry downward.

The root is held in a register. Every other node lives in one of four memory banks, and each bank has one read port and one write port. Node `i` (1-based, with children `2i` and `2i+1`) is stored in bank `i mod 4` at word `i / 4`. This places the four grandchildren `4i..4i+3` of any node in four different banks. During sift-down, all four grandchildren of the current node are read into registers in one cycle. In the next cycle, the two children needed for the comparison are picked from those registers, whichever way the previous comparison went. No path runs from one memory through comparison logic to another memory's address.

Every operation occupies the block for the same fixed number of cycles, whatever the data and whatever the outcome, so the queue's timing says nothing about its contents.

Top module: `banked_min_heap`

## Requirements
- R1: With `opExtract`=1, an accepted request removes the entry with the smallest key held and reports that key on `resKey` and the payload inserted with it on `resPay`, with `resFound`=1. Successive extracts return keys in ascending order.
- R2: After an accepted request, `opReady` stays low for exactly `OP_CYCLES` = clog2(CAP+1)+2 cycles (10 by default), independent of keys and outcome. `resValid` is a one-cycle pulse in the first cycle in which `opReady` is high again, and the result fields are valid during that pulse.
- R3: `count` changes in the cycle after acceptance: +1 for an accepted insert and -1 for an extract from a non-empty heap.
- R4: An extract while `count`=0 reports `resFound`=0 with `resKey` and `resPay` equal to 0, and `count` stays 0.
- R5: `full` is high exactly when `count` equals CAP. An insert made while full is refused: `resFound`=0, `count` is unchanged, and the stored entries are unchanged.
- R6: With `opExtract`=0, an accepted insert of `inKey`/`inPay` reports `resFound`=1 with `resKey` and `resPay` equal to 0.
- R7: `opValid` has no effect while `opReady` is low.
- R8: After reset, `opReady`=1, `resValid`=0, `count`=0 and `full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request present |
| opExtract | input | 1 | 1 = extract minimum, 0 = insert |
| inKey | input | KEY_W | Key to insert |
| inPay | input | clog2(CAP) | Payload index to insert |
| opReady | output | 1 | Block idle; a request is accepted when opValid is also high |
| resValid | output | 1 | One-cycle result strobe |
| resFound | output | 1 | Extract found an entry / insert was accepted |
| resKey | output | KEY_W | Extracted key |
| resPay | output | clog2(CAP) | Extracted payload |
| count | output | clog2(CAP+1) | Number of entries held |
| full | output | 1 | count equals CAP |

## Verification
A request is accepted at a rising edge. `count` and the drop of `opReady` are due one edge later, and `resValid` together with the result fields is due exactly ten edges after acceptance. The bench applies inputs and samples outputs on falling edges. It counts the falling edges from acceptance until `resValid` appears and compares that count with ten on every operation, so a latency that depends on the data shows up as a mismatch. A linear-scan reference model gives the expected minimum during a full fill and drain. A small table of vectors covers interleaved inserts and extracts.

// File: rtl/bmh_pkg.sv
package bmh_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic opAccept;
    logic insStart;
    logic extStart;
    logic extPrefetch;
    logic extStep;
    logic insStep;
  } heapStrobes_t;

endpackage

// File: rtl/bmh_bank.sv
// One heap memory bank: one synchronous read port, one write port.
module bmh_bank #(
  parameter int W     = 23,
  parameter int DEPTH = 33,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [W-1:0]  rdData,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/bmh_datapath.sv
// Root register, four banks, sift-up and sift-down comparators.
module bmh_datapath
  import bmh_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int CAP   = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  heapStrobes_t               strobe,
  input  logic [$clog2(CAP+1)-1:0]   count,
  input  logic [KEY_W-1:0]           inKey,
  input  logic [$clog2(CAP)-1:0]     inPay,
  output logic                       siftDone,
  output logic [KEY_W-1:0]           resKey,
  output logic [$clog2(CAP)-1:0]     resPay
);

  localparam int PAY_W      = $clog2(CAP);
  localparam int CNT_W      = $clog2(CAP+1);
  localparam int IDX_W      = CNT_W + 1;
  localparam int ENT_W      = KEY_W + PAY_W;
  localparam int BANK_DEPTH = CAP / 4 + 1;
  localparam int BA_W       = CNT_W - 2;
  localparam int NBANK      = 4;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic [PAY_W-1:0] pay;
  } entry_t;

  entry_t             rootE, movE, resE;
  logic [IDX_W-1:0]   cur;
  logic               sel;
  logic [1:0]         lastBank;

  logic [ENT_W-1:0]   bankQ [NBANK];
  entry_t             bankE [NBANK];

  // index arithmetic
  logic [IDX_W-1:0] countX, leftIdx, rightIdx, parIdx, gIdx, insParent;
  assign countX    = {1'b0, count};
  assign leftIdx   = {cur[IDX_W-2:0], 1'b0};
  assign rightIdx  = {cur[IDX_W-2:0], 1'b1};
  assign parIdx    = cur >> 1;
  assign gIdx      = cur >> 2;
  assign insParent = (countX + IDX_W'(1)) >> 1;

  // sift-down comparison on prefetched children
  entry_t ch0, ch1, picked, parE;
  logic   lv, rv, pickR, moveDown, moveUp;

  always_comb begin
    ch0      = bankE[{sel, 1'b0}];
    ch1      = bankE[{sel, 1'b1}];
    lv       = leftIdx  <= countX;
    rv       = rightIdx <= countX;
    pickR    = rv && (ch1.key < ch0.key);
    picked   = pickR ? ch1 : ch0;
    moveDown = lv && (picked.key < movE.key);
    parE     = (parIdx == IDX_W'(1)) ? rootE : bankE[parIdx[1:0]];
    moveUp   = (cur != IDX_W'(1)) && (movE.key < parE.key);
  end

  assign siftDone = (strobe.extStep && !moveDown) || (strobe.insStep && !moveUp);

  // single write per cycle into the node at cur
  logic   wrOn;
  entry_t wrData;
  always_comb begin
    wrOn   = (strobe.extStep || strobe.insStep) && (cur != IDX_W'(1));
    wrData = strobe.extStep ? (moveDown ? picked : movE)
                            : (moveUp ? parE : movE);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [1:0] BID = 2'(b);
    logic            rdEnB;
    logic [BA_W-1:0] rdAddrB;
    logic            wrEnB;

    always_comb begin
      rdEnB   = 1'b0;
      rdAddrB = '0;
      if (strobe.extStart) begin
        if (countX >= IDX_W'(2) && count[1:0] == BID) begin
          rdEnB   = 1'b1;
          rdAddrB = count[CNT_W-1:2];
        end
      end else if (strobe.extPrefetch) begin
        rdEnB   = 1'b1;
        rdAddrB = '0;
      end else if (strobe.extStep) begin
        if (cur < IDX_W'(BANK_DEPTH)) begin
          rdEnB   = 1'b1;
          rdAddrB = cur[BA_W-1:0];
        end
      end else if (strobe.insStart) begin
        if (insParent >= IDX_W'(2) && insParent[1:0] == BID) begin
          rdEnB   = 1'b1;
          rdAddrB = insParent[BA_W+1:2];
        end
      end else if (strobe.insStep) begin
        if (gIdx >= IDX_W'(2) && gIdx[1:0] == BID) begin
          rdEnB   = 1'b1;
          rdAddrB = gIdx[BA_W+1:2];
        end
      end
    end

    assign wrEnB = wrOn && (cur[1:0] == BID);

    bmh_bank #(.W(ENT_W), .DEPTH(BANK_DEPTH), .AW(BA_W)) u_bank (
      .clk    (clk),
      .rdEn   (rdEnB),
      .rdAddr (rdAddrB),
      .rdData (bankQ[b]),
      .wrEn   (wrEnB),
      .wrAddr (cur[BA_W+1:2]),
      .wrData (wrData)
    );

    assign bankE[b] = bankQ[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootE    <= '0;
      movE     <= '0;
      resE     <= '0;
      cur      <= '0;
      sel      <= 1'b0;
      lastBank <= '0;
    end else begin
      if (strobe.opAccept) resE <= '0;
      if (strobe.extStart) begin
        resE     <= rootE;
        lastBank <= count[1:0];
      end
      if (strobe.insStart) begin
        movE <= '{key: inKey, pay: inPay};
        cur  <= countX + IDX_W'(1);
        if (count == '0) rootE <= '{key: inKey, pay: inPay};
      end
      if (strobe.extPrefetch) begin
        movE <= bankE[lastBank];
        cur  <= IDX_W'(1);
        sel  <= 1'b1;
      end
      if (strobe.extStep) begin
        if (cur == IDX_W'(1)) rootE <= moveDown ? picked : movE;
        if (moveDown) begin
          cur <= {leftIdx[IDX_W-1:1], pickR};
          sel <= pickR;
        end
      end
      if (strobe.insStep) begin
        if (cur == IDX_W'(1)) rootE <= movE;
        else if (moveUp) cur <= parIdx;
      end
    end
  end

  assign resKey = resE.key;
  assign resPay = resE.pay;

  // R1
  heap_order_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.extStep && moveDown) |-> (picked.key >= rootE.key));

  // R1
  heap_order_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.insStep && moveUp) |-> (parE.key >= rootE.key));

endmodule

// File: rtl/bmh_ctrl.sv
// Fixed-occupancy sequencer and entry counter.
module bmh_ctrl
  import bmh_pkg::*;
#(
  parameter int CAP = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  logic                     opExtract,
  input  logic                     siftDone,
  output logic                     opReady,
  output logic                     resValid,
  output logic                     resFound,
  output logic [$clog2(CAP+1)-1:0] count,
  output logic                     full,
  output heapStrobes_t             strobe
);

  localparam int CNT_W     = $clog2(CAP+1);
  localparam int OP_CYCLES = CNT_W + 2;
  localparam int BC_W      = $clog2(OP_CYCLES + 1);

  typedef enum logic [2:0] {IDLE, EXT_PREF, EXT_DOWN, INS_UP, HOLD} ctrlState_t;

  ctrlState_t      state;
  logic [BC_W-1:0] busyCnt;
  logic            accept;

  assign opReady = (busyCnt == '0);
  assign accept  = opValid && opReady;
  assign full    = (count == CNT_W'(CAP));

  always_comb begin
    strobe.opAccept    = accept;
    strobe.insStart    = accept && !opExtract && !full;
    strobe.extStart    = accept && opExtract && (count != '0);
    strobe.extPrefetch = (state == EXT_PREF);
    strobe.extStep     = (state == EXT_DOWN);
    strobe.insStep     = (state == INS_UP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      busyCnt  <= '0;
      count    <= '0;
      resValid <= 1'b0;
      resFound <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (accept) begin
        busyCnt <= BC_W'(OP_CYCLES);
        if (opExtract) begin
          resFound <= (count != '0);
          if (count != '0) count <= count - CNT_W'(1);
          state <= (count > CNT_W'(1)) ? EXT_PREF : HOLD;
        end else begin
          resFound <= !full;
          if (!full) count <= count + CNT_W'(1);
          state <= (!full && count != '0) ? INS_UP : HOLD;
        end
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - BC_W'(1);
        case (state)
          EXT_PREF: state <= EXT_DOWN;
          EXT_DOWN: if (siftDone) state <= HOLD;
          INS_UP:   if (siftDone) state <= HOLD;
          default:  ;
        endcase
        if (busyCnt == BC_W'(1)) begin
          resValid <= 1'b1;
          state    <= IDLE;
        end
      end
    end
  end

  // R2
  sift_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == EXT_PREF || state == EXT_DOWN || state == INS_UP) |-> (busyCnt > BC_W'(1)));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !opReady);

  // R2
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R3
  count_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !opExtract && !full) |=> (count == $past(count) + CNT_W'(1)));

  // R4
  empty_extract_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opExtract && count == '0) |=> (count == '0 && !resFound));

  // R5
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !opExtract && full) |=> (count == $past(count) && full && !resFound));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opReady |=> (count == $past(count)));

endmodule

// File: rtl/banked_min_heap.sv
// Thin top: control sequencer plus banked heap datapath.
module banked_min_heap
  import bmh_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int CAP   = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  input  logic                     opExtract,
  input  logic [KEY_W-1:0]         inKey,
  input  logic [$clog2(CAP)-1:0]   inPay,
  output logic                     opReady,
  output logic                     resValid,
  output logic                     resFound,
  output logic [KEY_W-1:0]         resKey,
  output logic [$clog2(CAP)-1:0]   resPay,
  output logic [$clog2(CAP+1)-1:0] count,
  output logic                     full
);

  heapStrobes_t strobe;
  logic         siftDone;

  bmh_ctrl #(.CAP(CAP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opExtract (opExtract),
    .siftDone  (siftDone),
    .opReady   (opReady),
    .resValid  (resValid),
    .resFound  (resFound),
    .count     (count),
    .full      (full),
    .strobe    (strobe)
  );

  bmh_datapath #(.KEY_W(KEY_W), .CAP(CAP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .count    (count),
    .inKey    (inKey),
    .inPay    (inPay),
    .siftDone (siftDone),
    .resKey   (resKey),
    .resPay   (resPay)
  );

endmodule

// File: tb/banked_min_heap_bench.sv
`timescale 1ns/1ps
module banked_min_heap_bench;

  localparam int KEY_W = 16;
  localparam int CAP   = 128;
  localparam int PAY_W = 7;
  localparam int CNT_W = 8;
  localparam int OPC   = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             opValid = 1'b0;
  logic             opExtract = 1'b0;
  logic [KEY_W-1:0] inKey = '0;
  logic [PAY_W-1:0] inPay = '0;
  logic             opReady, resValid, resFound, full;
  logic [KEY_W-1:0] resKey;
  logic [PAY_W-1:0] resPay;
  logic [CNT_W-1:0] count;

  banked_min_heap #(.KEY_W(KEY_W), .CAP(CAP)) u_banked_min_heap (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opExtract(opExtract),
    .inKey(inKey), .inPay(inPay), .opReady(opReady), .resValid(resValid),
    .resFound(resFound), .resKey(resKey), .resPay(resPay),
    .count(count), .full(full)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model (linear scan)
  int mKey [CAP+4];
  int mPay [CAP+4];
  int mN = 0;

  // {ext, key, pay, expFound, expKey, expPay}
  localparam logic [47:0] VEC [13] = '{
    {1'b0, 16'd50, 7'd1, 1'b1, 16'd0,  7'd0},
    {1'b0, 16'd20, 7'd2, 1'b1, 16'd0,  7'd0},
    {1'b0, 16'd70, 7'd3, 1'b1, 16'd0,  7'd0},
    {1'b0, 16'd10, 7'd4, 1'b1, 16'd0,  7'd0},
    {1'b1, 16'd0,  7'd0, 1'b1, 16'd10, 7'd4},
    {1'b0, 16'd30, 7'd5, 1'b1, 16'd0,  7'd0},
    {1'b1, 16'd0,  7'd0, 1'b1, 16'd20, 7'd2},
    {1'b1, 16'd0,  7'd0, 1'b1, 16'd30, 7'd5},
    {1'b0, 16'd5,  7'd6, 1'b1, 16'd0,  7'd0},
    {1'b1, 16'd0,  7'd0, 1'b1, 16'd5,  7'd6},
    {1'b1, 16'd0,  7'd0, 1'b1, 16'd50, 7'd1},
    {1'b1, 16'd0,  7'd0, 1'b1, 16'd70, 7'd3},
    {1'b1, 16'd0,  7'd0, 1'b0, 16'd0,  7'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called at a falling edge; returns result and edges until resValid
  task automatic runOp(input logic ext, input logic [KEY_W-1:0] k, input logic [PAY_W-1:0] p,
                       output logic f, output logic [KEY_W-1:0] rk,
                       output logic [PAY_W-1:0] rp, output int lat);
    while (!opReady) @(negedge clk);
    opValid = 1'b1; opExtract = ext; inKey = k; inPay = p;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    lat = 0;
    while (!resValid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    f = resFound; rk = resKey; rp = resPay;
  endtask

  task automatic modelIns(input int k, input int p);
    if (mN < CAP) begin
      mKey[mN] = k; mPay[mN] = p; mN++;
    end
  endtask

  task automatic modelExt(output bit f, output int k, output int p);
    int best;
    f = (mN > 0); k = 0; p = 0;
    if (mN > 0) begin
      best = 0;
      for (int i = 1; i < mN; i++) if (mKey[i] < mKey[best]) best = i;
      k = mKey[best]; p = mPay[best];
      mKey[best] = mKey[mN-1]; mPay[best] = mPay[mN-1]; mN--;
    end
  endtask

  // op checked against the reference model
  task automatic modelOp(input logic ext, input int k, input int p, input string tag);
    logic f; logic [KEY_W-1:0] rk; logic [PAY_W-1:0] rp; int lat;
    bit ef; int ek, ep;
    runOp(ext, KEY_W'(k), PAY_W'(p), f, rk, rp, lat);
    if (ext) modelExt(ef, ek, ep);
    else begin
      ef = (mN < CAP); ek = 0; ep = 0;
      modelIns(k, p);
    end
    chk(f == ef && int'(rk) == ek && int'(rp) == ep, {tag, " key"}, int'(rk), ek);
    chk(lat == OPC, "R2 latency", lat, OPC);
    chk(int'(count) == mN, "R3 count", int'(count), mN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic f; logic [KEY_W-1:0] rk; logic [PAY_W-1:0] rp; int lat; int expCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(opReady == 1'b1, "R8 opReady", int'(opReady), 1);
    chk(resValid == 1'b0, "R8 resValid", int'(resValid), 0);
    chk(count == '0, "R8 count", int'(count), 0);
    chk(full == 1'b0, "R8 full", int'(full), 0);

    // vector table: R1 ordering, R6 insert result, R4 final empty extract
    expCnt = 0;
    for (int i = 0; i < 13; i++) begin
      logic [47:0] v;
      v = VEC[i];
      runOp(v[47], v[46:31], v[30:24], f, rk, rp, lat);
      if (v[23]) expCnt = v[47] ? expCnt - 1 : expCnt + 1;
      chk(f == v[23], v[47] ? "R1/R4 found" : "R6 found", int'(f), int'(v[23]));
      chk(rk == v[22:7] && rp == v[6:0], v[47] ? "R1/R4 key" : "R6 key", int'(rk), int'(v[22:7]));
      chk(lat == OPC, "R2 latency", lat, OPC);
      chk(int'(count) == expCnt, "R3 count", int'(count), expCnt);
      chk(opReady == 1'b1, "R2 ready with result", int'(opReady), 1);
    end

    // R7: requests while busy are ignored
    opValid = 1'b1; opExtract = 1'b0; inKey = 16'd40; inPay = 7'd9;
    @(posedge clk);
    @(negedge clk);
    chk(opReady == 1'b0, "R2 busy after accept", int'(opReady), 0);
    opExtract = 1'b1; inKey = 16'd1; inPay = 7'd1;
    repeat (5) @(negedge clk);
    opValid = 1'b0;
    while (!resValid) @(negedge clk);
    chk(count == 8'd1, "R7 count after busy requests", int'(count), 1);
    runOp(1'b1, 16'd0, 7'd0, f, rk, rp, lat);
    chk(f && rk == 16'd40 && rp == 7'd9, "R7 stored entry", int'(rk), 40);

    // descending inserts: every insert sifts to the root
    for (int i = 0; i < 20; i++) modelOp(1'b0, 500 - i * 7, i, "R6 desc");
    for (int i = 0; i < 20; i++) modelOp(1'b1, 0, 0, "R1 desc");

    // fill to capacity
    for (int i = 0; i < CAP; i++) modelOp(1'b0, ((i * 73 + 11) % 256) + 1, i, "R6 fill");
    chk(full == 1'b1, "R5 full flag", int'(full), 1);
    // refused insert with a key smaller than all stored
    runOp(1'b0, 16'd0, 7'd5, f, rk, rp, lat);
    chk(f == 1'b0, "R5 refused", int'(f), 0);
    chk(int'(count) == CAP, "R5 count kept", int'(count), CAP);
    chk(lat == OPC, "R2 latency refused", lat, OPC);
    // drain: sorted, and key 0 must not appear
    for (int i = 0; i < CAP; i++) modelOp(1'b1, 0, 0, "R1/R5 drain");
    chk(full == 1'b0, "R5 full clear", int'(full), 0);
    // R4 again
    runOp(1'b1, 16'd0, 7'd0, f, rk, rp, lat);
    chk(!f && rk == '0 && rp == '0 && count == '0, "R4 empty extract", int'(f), 0);

    finishRun();
  end

endmodule